// File: doc/BRIEF.md
# Gated Binary Up-Counter with Start Override

This block is a binary up-counter meant for clock division and for time measurement. Each rising clock edge either advances the count by one or leaves it where it is. Two enable inputs are combined by exclusive-OR and sampled on that same edge. When the two inputs agree, meaning both low or both high, the counter runs. When they disagree, it holds its last value.

A start level forces counting whatever the two enables say. It is combined in at the count register's input, so it acts only at a clock edge. An asynchronous clear, active low, drives the count to zero at once, without waiting for a clock.

Top module: `gated_binary_counter`

## Requirements
- R1: While `mclr_n` is low, `q` is zero. The clear takes effect as soon as `mclr_n` falls, without waiting for a clock edge.
- R2: When `en_a` = 0 and `en_b` = 0, each rising edge of `clk` adds one to `q`.
- R3: When exactly one of `en_a` and `en_b` is 1 at a rising edge, and `start_lvl` is 0, `q` keeps its value through that edge. This also applies to the first edge at which the disagreement appears.
- R4: When `en_a` = 1 and `en_b` = 1, each rising edge adds one to `q`. This includes the first edge after a hold.
- R5: When the enables agree again after a hold, counting resumes on that same edge, continuing from the held value.
- R6: When `start_lvl` = 1 at a rising edge, `q` advances by one whatever values `en_a` and `en_b` have.
- R7: A change on `start_lvl` between clock edges does not alter `q` before the next rising edge.
- R8: When `q` = 8'hFF and the counter advances, the next value is 8'h00.
- R9: After `mclr_n` goes high with both enables low, the first rising edge gives `q` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; all updates occur on its rising edge |
| mclr_n | input | 1 | Asynchronous clear, active low |
| en_a | input | 1 | First synchronous enable; counting when it equals `en_b` |
| en_b | input | 1 | Second synchronous enable |
| start_lvl | input | 1 | Start override level; forces counting at the clock edge |
| q | output | W (8) | Current count |

## Verification
On every clock edge, the assertions check the per-edge rules: increment when the enables agree or start is high, hold when the enables disagree, wrap from all-ones to zero, and zero while the clear is held.

Only the bench scenarios can show the timing relations between edges:
- the asynchronous clear landing between edges;
- a start level raised mid-cycle leaving the count untouched until the edge;
- the resume after a hold continuing from exactly the held value;
- the first count after the clear is released.

// File: rtl/gbc_pkg.sv
// Package: shared types and default width for the gated binary counter.
// Assumes: all users take their count width from a module parameter whose
// default is DEF_CNT_W.
package gbc_pkg;

    // Default count width
    localparam int unsigned DEF_CNT_W = 8;

    // Decoded run request: agreement of the two enables, and the start level
    typedef struct packed {
        logic agree;
        logic forced;
    } run_req_t;

endpackage

// File: rtl/gbc_run_gate.sv
// Module: gbc_run_gate
// Combines the two synchronous enables by exclusive-OR and merges the start
// override. The result is the step request sampled by the count register at
// the clock edge.
// Assumes: inputs are levels. The register that consumes step_o provides the
// edge capture, so the enable value present at an edge is the one applied.
module gbc_run_gate
    import gbc_pkg::*;
(
    input  logic     en_a_i,
    input  logic     en_b_i,
    input  logic     start_i,
    output run_req_t req_o,
    output logic     step_o
);

    // Decode agreement of the enables and pass the start level through
    always_comb begin
        req_o.agree  = ~(en_a_i ^ en_b_i);
        req_o.forced = start_i;
    end

    // Start overrides a hold request
    always_comb begin
        step_o = req_o.agree | req_o.forced;
    end

endmodule

// File: rtl/gbc_toggle_chain.sv
// Module: gbc_toggle_chain
// Next-count logic built as a chain of toggle cells. Bit i flips when the
// step is requested and every lower bit is one. This gives the same sequence
// as a ripple counter but in one clock domain. All-ones wraps to zero.
// Assumes: W >= 1.
module gbc_toggle_chain #(
    parameter int unsigned W = gbc_pkg::DEF_CNT_W
) (
    input  logic         step_i,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);

    localparam int unsigned CW = W + 1;

    logic [CW-1:0] carry;

    // Seed the carry chain with the step request
    always_comb begin
        carry[0] = step_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_cell
            // One toggle cell: flip on incoming carry, pass carry when set
            always_comb begin
                nxt_o[gi]     = cur_i[gi] ^ carry[gi];
                carry[gi + 1] = carry[gi] & cur_i[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/gbc_count_reg.sv
// Module: gbc_count_reg
// Count register with an asynchronous clear.
// Assumes: mclr_n_i is active low. Its release is synchronised by the
// surrounding logic, away from the clock edge.
module gbc_count_reg #(
    parameter int unsigned W = gbc_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         mclr_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Hold the count; clear immediately on the asynchronous clear
    always_ff @(posedge clk or negedge mclr_n_i) begin
        if (!mclr_n_i) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/gated_binary_counter.sv
// Module: gated_binary_counter (top)
// Binary up-counter with enables combined by exclusive-OR, a start override,
// and an asynchronous clear.
// Assumes: en_a, en_b and start_lvl are stable around the rising clock edge.
module gated_binary_counter
    import gbc_pkg::*;
#(
    parameter int unsigned W = DEF_CNT_W
) (
    input  logic         clk,
    input  logic         mclr_n,
    input  logic         en_a,
    input  logic         en_b,
    input  logic         start_lvl,
    output logic [W-1:0] q
);

    run_req_t       req;
    logic           step;
    logic [W-1:0]   cnt_nxt;

    // Enable decode and start merge
    gbc_run_gate u_gate (
        .en_a_i  (en_a),
        .en_b_i  (en_b),
        .start_i (start_lvl),
        .req_o   (req),
        .step_o  (step)
    );

    // Next-count computation
    gbc_toggle_chain #(.W(W)) u_chain (
        .step_i (step),
        .cur_i  (q),
        .nxt_o  (cnt_nxt)
    );

    // Count storage
    gbc_count_reg #(.W(W)) u_reg (
        .clk      (clk),
        .mclr_n_i (mclr_n),
        .d_i      (cnt_nxt),
        .q_o      (q)
    );

endmodule

// File: rtl/gbc_checker.sv
// Module: gbc_checker
// Edge-by-edge properties of the counter, checked at its ports.
// Assumes: it is bound to gated_binary_counter.
module gbc_checker #(
    parameter int unsigned W = gbc_pkg::DEF_CNT_W
) (
    input logic         clk,
    input logic         mclr_n,
    input logic         en_a,
    input logic         en_b,
    input logic         start_lvl,
    input logic [W-1:0] q
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] FULL = '1;

    // R1
    clear_zero_chk: assert property (@(posedge clk) !mclr_n |-> q == '0);

    // R2 R4
    agree_step_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        (en_a == en_b) |=> q == $past(q) + ONE);

    // R3
    split_hold_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        ((en_a != en_b) && !start_lvl) |=> q == $past(q));

    // R6
    start_force_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        start_lvl |=> q == $past(q) + ONE);

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!mclr_n)
        (q == FULL && (start_lvl || en_a == en_b)) |=> q == '0);

endmodule

bind gated_binary_counter gbc_checker #(.W(W)) u_gbc_chk (
    .clk       (clk),
    .mclr_n    (mclr_n),
    .en_a      (en_a),
    .en_b      (en_b),
    .start_lvl (start_lvl),
    .q         (q)
);

// File: tb/gated_binary_counter_tb_top.sv
// Bench: directed corners followed by seeded random stimulus, compared
// against a reference count kept in the bench.
module gated_binary_counter_tb_top;

    localparam int CLK_P = 10;
    localparam int W     = 8;

    logic         clk = 1'b0;
    logic         mclr_n = 1'b0;
    logic         en_a = 1'b0;
    logic         en_b = 1'b0;
    logic         start_lvl = 1'b0;
    logic [W-1:0] q;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [W-1:0] ref_q = '0;
    bit           done = 1'b0;

    gated_binary_counter #(.W(W)) dut_i (
        .clk       (clk),
        .mclr_n    (mclr_n),
        .en_a      (en_a),
        .en_b      (en_b),
        .start_lvl (start_lvl),
        .q         (q)
    );

    // Free-running clock
    always #(CLK_P/2) clk = ~clk;

    // Compare one observed value against its expected value
    task automatic chk(input string rid, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s q=%0h expected=%0h at %0t", rid, act, exp, $time);
        end
    endtask

    // Expected next count under the requirements
    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
                                                input logic a, input logic b, input logic s);
        return (s || (a == b)) ? cur + 1'b1 : cur;
    endfunction

    // Requirement that a given edge exercises
    function automatic string tag_of(input logic [W-1:0] cur,
                                     input logic a, input logic b, input logic s);
        if (cur == '1 && (s || a == b)) return "R8";
        if (s && (a != b))              return "R6";
        if (a != b)                     return "R3";
        if (a && b)                     return "R4";
        return "R2";
    endfunction

    // Called at a falling edge: drive inputs, pass the rising edge, check, return to the falling edge
    task automatic tick(input logic a, input logic b, input logic s, input string force_tag = "");
        logic [W-1:0] exp;
        string        t;
        en_a = a; en_b = b; start_lvl = s;
        exp = model_next(ref_q, a, b, s);
        t   = (force_tag != "") ? force_tag : tag_of(ref_q, a, b, s);
        @(posedge clk);
        #1;
        ref_q = exp;
        chk(t, q, exp);
        @(negedge clk);
    endtask

    // Called at a falling edge: pulse the clear between edges
    task automatic mid_clear();
        #2;
        mclr_n = 1'b0;
        #1;
        chk("R1", q, '0);
        @(negedge clk);
        chk("R1", q, '0);
        mclr_n = 1'b1;
        ref_q = '0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (2) @(negedge clk);
        chk("R1", q, '0);
        mclr_n = 1'b1;
        // R9: first edge after release with both enables low
        tick(1'b0, 1'b0, 1'b0, "R9");
        tick(1'b0, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        // R3: disagreement holds from its first edge
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        // R5: resume from the held value on the first agreeing edge
        tick(1'b1, 1'b1, 1'b0, "R5");
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0, "R5");
        // R6: start forces counting over a hold request
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b0, 1'b1, 1'b1);
        // R7: start raised between edges leaves q untouched until the edge
        en_a = 1'b1; en_b = 1'b0; start_lvl = 1'b0;
        #1;
        start_lvl = 1'b1;
        #2;
        chk("R7", q, ref_q);
        tick(1'b1, 1'b0, 1'b1);
        // R8: run up to all-ones and wrap
        while (ref_q != '1) tick(1'b0, 1'b0, 1'b0);
        tick(1'b1, 1'b1, 1'b0);
        chk("R8", q, '0);
        // R1: clear mid-count
        tick(1'b0, 1'b0, 1'b0);
        mid_clear();
        tick(1'b0, 1'b0, 1'b0, "R9");
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic ra, rb, rs;
            ra = 1'($urandom);
            rb = 1'($urandom);
            rs = ($urandom % 6) == 0;
            if (($urandom % 97) == 0) mid_clear();
            tick(ra, rb, rs);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule